// File: doc/BRIEF.md
# Invertible Binary Matrix Address Scrambler

This block turns a logical line address into an intermediate address by multiplying it with a square binary matrix over GF(2). In this arithmetic, multiplication is AND and addition is XOR. The scrambled address then goes to a wear-leveling remapper. Lines that are written heavily and sit next to each other in the logical space end up far apart, so the remapper does not keep moving one hot line onto another hot line.

The matrix is held in registers and comes out of reset as the identity, so addresses pass through unchanged until software loads something else. Software loads new rows one at a time through a configuration port, then issues a commit. When the check is enabled, the commit starts a rank check. The check does Gaussian elimination, one column per cycle. Translation resumes only if every column finds a pivot. A singular matrix raises a sticky flag and leaves translation disabled. The mapping does not change while translation is running.

Top module: `addr_scrambler`

## Requirements
- R1: After reset, the matrix is the identity, `configured` is 1, and `chk_busy` and `chk_singular` are 0, so a translated address equals its input.
- R2: Bit i of `out_addr` is the XOR over all j of (row i bit j AND input bit j). It appears one cycle after the input is sampled and uses the matrix in force at that sampling edge.
- R3: `out_valid` is 1 exactly one cycle after an edge where `in_valid` was 1 and `configured` was 1. Inputs sampled while `configured` is 0 are dropped.
- R4: A row write (`cfg_we`) stores `cfg_data` as row `cfg_row`, where bit j of the row multiplies address bit j. The new row applies to inputs sampled from the next edge on. The same edge clears `configured` and `chk_singular` and cancels a running check.
- R5: `cfg_commit` with `cfg_we` low starts the rank check, raising `chk_busy` on the next cycle and clearing `configured`. A commit in the same cycle as a row write is ignored.
- R6: For an invertible matrix, `chk_busy` stays high for exactly AW cycles (AW is the address width, default 8). After that, `configured` is 1 and `chk_singular` is 0.
- R7: For a singular matrix, let f be the lowest column index whose column vector is in the span of columns 0..f-1. `chk_busy` stays high for f+1 cycles. Then `chk_singular` is 1 and `configured` stays 0.
- R8: Once a committed invertible matrix is in force, translating all 2^AW addresses yields 2^AW distinct outputs.
- R9: A commit issued while a check is running restarts the check. `chk_busy` then stays high for the full check length measured from the restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Row write strobe |
| cfg_row | input | $clog2(AW) | Index of the row being written |
| cfg_data | input | AW | Row contents; bit j multiplies address bit j |
| cfg_commit | input | 1 | Ends loading; starts the rank check |
| in_valid | input | 1 | Input address valid |
| in_addr | input | AW | Logical line address |
| out_valid | output | 1 | Scrambled address valid |
| out_addr | output | AW | Intermediate address |
| configured | output | 1 | Translation enabled |
| chk_busy | output | 1 | Rank check in progress |
| chk_singular | output | 1 | Last check found the matrix singular |

## Verification
The bench loads a scrambled invertible matrix built from row additions and sweeps every address through it. A wrong row-to-bit orientation, or a parity taken over the wrong operand, would produce mismatched or colliding outputs. Two kinds of singular matrix are used: one with an all-zero first column, which must fail on the first busy cycle, and one with two equal rows, which must fail at the first dependent column. A checker that always ran the full length, or that skipped the pivot search, would misreport the busy length or the flag. A mid-check row write and a mid-check recommit are also driven. A design that let a stale check finish would re-enable translation with an unchecked matrix or end early. Inputs offered while unconfigured must vanish. A design that did not gate on the flag would emit addresses from a half-loaded matrix.

// File: rtl/scr_pkg.sv
package scr_pkg;
  typedef enum logic {CHK_IDLE, CHK_RUN} chk_state_e;
  localparam int unsigned SCR_MIN_AW = 2;
endpackage

// File: rtl/scr_matrix.sv
module scr_matrix #(
  parameter int AW = 8,
  localparam int RW = $clog2(AW)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [RW-1:0]          wr_row,
  input  logic [AW-1:0]          wr_data,
  output logic [AW-1:0][AW-1:0]  mat
);
  localparam logic [AW-1:0] ONE = AW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < AW; r++) mat[r] <= ONE << r;
    end else if (wr_en) begin
      mat[wr_row] <= wr_data;
    end
  end

  // R4: a written row holds the written data on the following cycle
  a_r4_row_stored: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mat[$past(wr_row)] == $past(wr_data));
endmodule

// File: rtl/scr_xform.sv
module scr_xform #(
  parameter int AW = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [AW-1:0][AW-1:0]  mat,
  input  logic                   en,
  input  logic                   in_valid,
  input  logic [AW-1:0]          in_addr,
  output logic                   out_valid,
  output logic [AW-1:0]          out_addr
);
  function automatic logic [AW-1:0] gf2_mat_vec(input logic [AW-1:0][AW-1:0] m,
                                                input logic [AW-1:0] v);
    logic [AW-1:0] res;
    for (int i = 0; i < AW; i++) res[i] = ^(m[i] & v);
    return res;
  endfunction

  logic          accept;
  logic [AW-1:0] prod;

  assign accept = in_valid && en;
  assign prod   = gf2_mat_vec(mat, in_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
    end else begin
      out_valid <= accept;
      if (accept) out_addr <= prod;
    end
  end

  // R3: an output beat always stems from an accepted input one cycle earlier
  a_r3_valid_source: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid) && $past(en));
  // R3: nothing is emitted when translation was disabled
  a_r3_drop_unconfigured: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !out_valid);
endmodule

// File: rtl/scr_rank_check.sv
module scr_rank_check #(
  parameter int AW = 8,
  localparam int CW = (AW > 1) ? $clog2(AW) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [AW-1:0][AW-1:0]  mat,
  input  logic                   start,
  input  logic                   abort,
  output logic                   busy,
  output logic                   fin_pass,
  output logic                   fin_fail
);
  import scr_pkg::*;

  localparam logic [CW-1:0] LAST_COL = CW'(AW - 1);

  function automatic logic [AW-1:0] lowest_one(input logic [AW-1:0] v);
    logic [AW-1:0] oh;
    logic          seen;
    oh   = '0;
    seen = 1'b0;
    for (int k = 0; k < AW; k++) begin
      if (v[k] && !seen) begin
        oh[k] = 1'b1;
        seen  = 1'b1;
      end
    end
    return oh;
  endfunction

  chk_state_e            state;
  logic [AW-1:0][AW-1:0] work;
  logic [AW-1:0][AW-1:0] work_nx;
  logic [AW-1:0]         used;
  logic [CW-1:0]         col;
  logic [AW-1:0]         cand;
  logic [AW-1:0]         piv_oh;
  logic [AW-1:0]         piv_row;
  logic                  have_piv;
  logic                  step;

  always_comb begin
    for (int r = 0; r < AW; r++) cand[r] = !used[r] && work[r][col];
    piv_oh   = lowest_one(cand);
    have_piv = |cand;
    piv_row  = '0;
    for (int r = 0; r < AW; r++) if (piv_oh[r]) piv_row = piv_row | work[r];
    for (int r = 0; r < AW; r++)
      work_nx[r] = (work[r][col] && !piv_oh[r]) ? (work[r] ^ piv_row) : work[r];
  end

  assign busy     = (state == CHK_RUN);
  assign step     = busy && !start && !abort;
  assign fin_fail = step && !have_piv;
  assign fin_pass = step && have_piv && (col == LAST_COL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= CHK_IDLE;
      work  <= '0;
      used  <= '0;
      col   <= '0;
    end else if (abort) begin
      state <= CHK_IDLE;
    end else if (start) begin
      state <= CHK_RUN;
      work  <= mat;
      used  <= '0;
      col   <= '0;
    end else if (fin_fail || fin_pass) begin
      state <= CHK_IDLE;
    end else if (step) begin
      work <= work_nx;
      used <= used | piv_oh;
      col  <= col + CW'(1);
    end
  end

  // R6: the check never ends both ways in one cycle
  a_r6_single_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    !(fin_pass && fin_fail));
  // R5: a start that is not aborted makes the checker busy
  a_r5_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start && !abort |=> busy);
  // R7: a failing step ends the run
  a_r7_fail_ends: assert property (@(posedge clk) disable iff (!rst_n)
    fin_fail |=> !busy);
  // R6: pivot rows chosen so far are at most one per processed column
  a_r6_pivot_count: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $countones(used) == int'(col));
endmodule

// File: rtl/addr_scrambler.sv
module addr_scrambler #(
  parameter int AW       = 8,
  parameter bit CHECK_EN = 1'b1,
  localparam int RW = $clog2(AW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [RW-1:0] cfg_row,
  input  logic [AW-1:0] cfg_data,
  input  logic          cfg_commit,
  input  logic          in_valid,
  input  logic [AW-1:0] in_addr,
  output logic          out_valid,
  output logic [AW-1:0] out_addr,
  output logic          configured,
  output logic          chk_busy,
  output logic          chk_singular
);
  localparam logic [RW:0] ROWS = (RW + 1)'(AW);

  logic [AW-1:0][AW-1:0] mat;
  logic                  row_wr;
  logic                  commit_ok;
  logic                  chk_pass;
  logic                  chk_fail;

  assign row_wr    = cfg_we && ({1'b0, cfg_row} < ROWS);
  assign commit_ok = cfg_commit && !cfg_we;

  scr_matrix #(.AW(AW)) u_mat (
    .clk(clk), .rst_n(rst_n), .wr_en(row_wr), .wr_row(cfg_row),
    .wr_data(cfg_data), .mat(mat)
  );

  scr_xform #(.AW(AW)) u_xf (
    .clk(clk), .rst_n(rst_n), .mat(mat), .en(configured),
    .in_valid(in_valid), .in_addr(in_addr),
    .out_valid(out_valid), .out_addr(out_addr)
  );

  generate
    if (CHECK_EN) begin : g_chk
      scr_rank_check #(.AW(AW)) u_chk (
        .clk(clk), .rst_n(rst_n), .mat(mat), .start(commit_ok),
        .abort(row_wr), .busy(chk_busy), .fin_pass(chk_pass), .fin_fail(chk_fail)
      );
    end else begin : g_nochk
      assign chk_busy = 1'b0;
      assign chk_pass = 1'b0;
      assign chk_fail = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      configured   <= 1'b1;
      chk_singular <= 1'b0;
    end else if (row_wr) begin
      configured   <= 1'b0;
      chk_singular <= 1'b0;
    end else if (commit_ok) begin
      configured   <= !CHECK_EN;
      chk_singular <= 1'b0;
    end else if (chk_pass) begin
      configured   <= 1'b1;
    end else if (chk_fail) begin
      chk_singular <= 1'b1;
    end
  end

  // R4: a row write disables translation on the next cycle
  a_r4_write_disables: assert property (@(posedge clk) disable iff (!rst_n)
    row_wr |=> !configured && !chk_singular);
  // R6: a passing check enables translation
  a_r6_pass_enables: assert property (@(posedge clk) disable iff (!rst_n)
    chk_pass |=> configured && !chk_singular);
  // R7: a failing check flags singular and keeps translation off
  a_r7_fail_flags: assert property (@(posedge clk) disable iff (!rst_n)
    chk_fail |=> chk_singular && !configured);
  // R5: translation is never enabled while a check is running
  a_r5_no_cfg_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    chk_busy |-> !configured);
endmodule

// File: tb/addr_scrambler_tb.sv
`timescale 1ns/1ps
module addr_scrambler_tb;
  localparam int AW = 8;
  localparam int RW = $clog2(AW);
  localparam int NA = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [RW-1:0] cfg_row = '0;
  logic [AW-1:0] cfg_data = '0;
  logic          cfg_commit = 1'b0;
  logic          in_valid = 1'b0;
  logic [AW-1:0] in_addr = '0;
  logic          out_valid;
  logic [AW-1:0] out_addr;
  logic          configured;
  logic          chk_busy;
  logic          chk_singular;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  addr_scrambler #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_row(cfg_row),
    .cfg_data(cfg_data), .cfg_commit(cfg_commit), .in_valid(in_valid),
    .in_addr(in_addr), .out_valid(out_valid), .out_addr(out_addr),
    .configured(configured), .chk_busy(chk_busy), .chk_singular(chk_singular)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int unsigned mrow [AW];
  bit mcfg, mbusy, msing, mov;
  int mcnt, mfail, moa;

  function automatic int gf2_apply(input int a);
    int res = 0;
    for (int i = 0; i < AW; i++) begin
      int p = 0;
      for (int j = 0; j < AW; j++) p = p ^ (((mrow[i] >> j) & 1) & ((a >> j) & 1));
      res = res | (p << i);
    end
    return res;
  endfunction

  // first column lying in the span of the earlier columns; AW if none
  function automatic int first_dependent_col();
    int basis [AW];
    for (int b = 0; b < AW; b++) basis[b] = 0;
    for (int k = 0; k < AW; k++) begin
      int v = 0;
      for (int r = 0; r < AW; r++) v = v | (((mrow[r] >> k) & 1) << r);
      for (int b = AW - 1; b >= 0; b--) begin
        if (((v >> b) & 1) != 0) begin
          if (basis[b] == 0) begin
            basis[b] = v;
            v = -1;
            break;
          end
          v = v ^ basis[b];
        end
      end
      if (v == 0) return k;
    end
    return AW;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < AW; r++) mrow[r] = 1 << r;
      mcfg = 1; mbusy = 0; msing = 0; mov = 0; mcnt = 0; mfail = AW; moa = 0;
    end else begin
      mov = in_valid && mcfg;
      if (mov) moa = gf2_apply(int'(in_addr));
      if (cfg_we) begin
        mrow[cfg_row] = cfg_data;
        mcfg = 0; mbusy = 0; msing = 0;
      end else if (cfg_commit) begin
        mbusy = 1; mcnt = 0; mfail = first_dependent_col(); msing = 0; mcfg = 0;
      end else if (mbusy) begin
        if (mcnt == mfail) begin mbusy = 0; msing = 1; end
        else if (mcnt == AW - 1) begin mbusy = 0; mcfg = 1; end
        else mcnt++;
      end
    end
  end

  bit collect = 0;
  bit seen [NA];
  int distinct = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      check(out_valid == mov, "R3 out_valid", out_valid, mov);
      if (mov) check(out_addr == AW'(moa), "R2 out_addr", out_addr, moa);
      check(configured == mcfg, "R4 configured", configured, mcfg);
      check(chk_busy == mbusy, "R5 chk_busy", chk_busy, mbusy);
      check(chk_singular == msing, "R7 chk_singular", chk_singular, msing);
      if (collect && out_valid && !seen[out_addr]) begin
        seen[out_addr] = 1;
        distinct++;
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic put_row(input int r, input int d);
    @(negedge clk);
    cfg_we = 1; cfg_row = RW'(r); cfg_data = AW'(d);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic commit_and_count(output int n);
    @(negedge clk);
    cfg_commit = 1;
    @(negedge clk);
    cfg_commit = 0;
    n = 0;
    while (chk_busy) begin n++; @(negedge clk); end
  endtask

  task automatic send(input int a);
    @(negedge clk);
    in_valid = 1; in_addr = AW'(a);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic finish_up();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    finish_up();
  end

  int unsigned good [AW];
  int n, seed, f;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(configured == 1 && chk_busy == 0 && chk_singular == 0, "R1 reset flags",
          {configured, chk_busy, chk_singular}, 3'b100);
    @(negedge clk); in_valid = 1; in_addr = 8'hA5;
    @(negedge clk); in_valid = 0;
    check(out_valid && out_addr == 8'hA5, "R1 identity passthrough", out_addr, 8'hA5);

    // build an invertible matrix from row additions
    for (int r = 0; r < AW; r++) good[r] = 1 << r;
    seed = 7;
    for (int it = 0; it < 40; it++) begin
      int i, j;
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      i = (seed >> 8) % AW;
      j = (seed >> 16) % AW;
      if (i != j) good[i] = good[i] ^ good[j];
    end
    for (int r = 0; r < AW; r++) put_row(r, good[r]);
    check(configured == 0, "R4 write clears configured", configured, 0);
    send(8'h3C);   // dropped while unconfigured (R3, checked by model)
    commit_and_count(n);
    check(n == AW, "R6 busy length invertible", n, AW);
    check(configured == 1 && chk_singular == 0, "R6 enabled after pass",
          {configured, chk_singular}, 2'b10);

    // R8 full sweep, one address per cycle
    collect = 1;
    for (int a = 0; a < NA; a++) begin
      @(negedge clk); in_valid = 1; in_addr = AW'(a);
    end
    @(negedge clk); in_valid = 0;
    @(negedge clk); collect = 0;
    check(distinct == NA, "R8 outputs distinct", distinct, NA);

    // R9 restart mid-check
    @(negedge clk); cfg_commit = 1;
    @(negedge clk); cfg_commit = 0;
    repeat (2) @(negedge clk);
    commit_and_count(n);
    check(n == AW, "R9 restart busy length", n, AW);

    // R5 commit together with a write is ignored
    @(negedge clk); cfg_we = 1; cfg_commit = 1; cfg_row = 0; cfg_data = AW'(good[0]);
    @(negedge clk); cfg_we = 0; cfg_commit = 0;
    @(negedge clk);
    check(chk_busy == 0 && configured == 0, "R5 commit with write ignored",
          {chk_busy, configured}, 2'b00);

    // R4 write during a check aborts it
    @(negedge clk); cfg_commit = 1;
    @(negedge clk); cfg_commit = 0;
    @(negedge clk);
    put_row(3, good[3]);
    repeat (AW + 2) @(negedge clk);
    check(configured == 0 && chk_busy == 0, "R4 abort keeps disabled",
          {configured, chk_busy}, 2'b00);
    commit_and_count(n);

    // R7 singular: zero first column
    for (int r = 0; r < AW; r++) put_row(r, (1 << r) & ~1);
    commit_and_count(n);
    check(n == 1, "R7 zero column busy length", n, 1);
    check(chk_singular == 1 && configured == 0, "R7 singular flagged",
          {chk_singular, configured}, 2'b10);
    send(8'h11);

    // R7 singular: two equal rows
    for (int r = 0; r < AW; r++) put_row(r, good[r]);
    put_row(5, good[2]);
    f = first_dependent_col();
    commit_and_count(n);
    check(n == f + 1, "R7 equal rows busy length", n, f + 1);
    check(chk_singular == 1, "R7 equal rows flagged", chk_singular, 1);

    // back to identity, passthrough again
    for (int r = 0; r < AW; r++) put_row(r, 1 << r);
    commit_and_count(n);
    send(8'h5A);
    check(configured == 1, "R6 identity recommitted", configured, 1);
    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule